// File: doc/BRIEF.md
# Postfix Expression Evaluator with Hardware Operand Stack

This block evaluates arithmetic written in postfix (reverse Polish) order. A producer hands it one token per valid/ready handshake. A token is either a number or a command. Numbers go onto a small internal operand stack. An arithmetic command takes the two newest entries, combines them, and leaves the single outcome in their place. A terminating command hands the finished value to the result port. The producer is expected to split text into tokens before they reach the block.

Values are signed two's-complement words of `W` bits, and the stack holds `DEPTH` of them. Addition, subtraction and multiplication complete in the accepting cycle. Division runs on a shift-subtract engine for `W` cycles, and `in_ready` stays low for that time. Misuse does not stop the block. It raises one of four error pulses and carries on: too many operands, too few operands, a zero divisor, or a terminating command with a stack that does not hold exactly one value. The stack depth never appears on a port. Only the empty and full indications are visible.

Top module: `rpn_eval`

## Requirements
- R1: After reset, `stk_empty` is 1, `stk_full` is 0, `in_ready` is 1, and `res_valid` and all four error outputs are 0.
- R2: A token with `in_kind` = 0 (number) places `in_value` on the stack top. `stk_full` is 1 exactly when `DEPTH` entries are held, and `stk_empty` is 1 exactly when none are held.
- R3: `in_kind` 1 (add), 2 (subtract) and 3 (multiply) remove the two newest entries and push one value. The newest entry is the right operand and the one below it is the left operand. Results wrap modulo 2^W.
- R4: `in_kind` 4 (divide) pushes the signed quotient left/right, truncated toward zero, with the most negative value divided by -1 wrapping to itself. `in_ready` is 0 from the cycle after acceptance until the quotient is on the stack.
- R5: A divide whose right operand is zero raises `err_divzero` and pushes 0 in place of the two operands.
- R6: An arithmetic command (kinds 1 to 4) that finds fewer than two entries raises `err_underflow` and leaves the stack contents unchanged.
- R7: A number token that arrives while the stack is full raises `err_overflow` and is discarded. The stack contents are unchanged.
- R8: `in_kind` 5 (end) with exactly one entry pulses `res_valid` with that entry on `res_value` and leaves the stack empty.
- R9: `in_kind` 5 with zero or more than one entry raises `err_malformed`, produces no result, and empties the stack.
- R10: `in_kind` 6 and 7 are accepted and have no effect on the stack, the result port or the error outputs.
- R11: `res_valid` and each error output are single-cycle pulses in the cycle after acceptance. At most one of the four error outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token can be taken this cycle |
| in_kind | input | 3 | Token kind: 0 number, 1 add, 2 sub, 3 mul, 4 div, 5 end, 6-7 ignored |
| in_value | input | W | Number carried by a kind-0 token |
| res_valid | output | 1 | Result pulse |
| res_value | output | W | Finished expression value |
| stk_empty | output | 1 | Stack holds no entry |
| stk_full | output | 1 | Stack holds DEPTH entries |
| err_overflow | output | 1 | Number dropped on a full stack |
| err_underflow | output | 1 | Command found fewer than two entries |
| err_divzero | output | 1 | Divide by zero, 0 pushed |
| err_malformed | output | 1 | End found other than one entry |

## Verification
The bound checker watches properties that hold in every cycle. It checks that the error pulses are mutually exclusive, that empty and full never coincide, and that a result is followed by an empty stack and cannot repeat in the next cycle. It also checks that an overflow pulse is seen with a full stack, and that an idle cycle leaves the stack indications steady. The bench covers what only a reference model can show. This includes operand order for subtraction and division, wrapping products, truncation toward zero on mixed signs, and contents left intact after an underflow or an overflow. It also covers the recovery after a malformed end. These are checked with directed corner cases and a seeded random token stream.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    typedef enum logic [2:0] {
        TK_NUM  = 3'd0,
        TK_ADD  = 3'd1,
        TK_SUB  = 3'd2,
        TK_MUL  = 3'd3,
        TK_DIV  = 3'd4,
        TK_END  = 3'd5,
        TK_RSV6 = 3'd6,
        TK_RSV7 = 3'd7
    } tok_kind_e;

    typedef enum logic [2:0] {
        SOP_HOLD  = 3'd0,
        SOP_PUSH  = 3'd1,
        SOP_FOLD  = 3'd2,
        SOP_POP   = 3'd3,
        SOP_CLEAR = 3'd4
    } stk_op_e;

    typedef enum logic {
        CT_IDLE   = 1'b0,
        CT_DIVIDE = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic dz;
        logic bad;
    } err_flags_t;

    function automatic logic is_arith(tok_kind_e k);
        return (k == TK_ADD) || (k == TK_SUB) || (k == TK_MUL) || (k == TK_DIV);
    endfunction

endpackage

// File: rtl/rpn_stack.sv
module rpn_stack
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  stk_op_e          op,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     top,
    output logic [W-1:0]     nxt,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    logic [CNT_W-1:0] cnt_q;
    logic [W-1:0]     mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (op)
                SOP_PUSH:  cnt_q <= cnt_q + 1'b1;
                SOP_FOLD:  cnt_q <= cnt_q - 1'b1;
                SOP_POP:   cnt_q <= cnt_q - 1'b1;
                SOP_CLEAR: cnt_q <= '0;
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (op == SOP_PUSH && int'(cnt_q) == i) begin
                mem[i] <= wdata;
            end else if (op == SOP_FOLD && int'(cnt_q) == i + 2) begin
                mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        top = '0;
        nxt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(cnt_q) == i + 1) top = mem[i];
            if (int'(cnt_q) == i + 2) nxt = mem[i];
        end
    end

    assign count = cnt_q;
    assign empty = (cnt_q == '0);
    assign full  = (int'(cnt_q) == DEPTH);

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int W = 16
) (
    input  tok_kind_e    kind,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);

    logic [W-1:0] sum, dif, prod;

    assign sum  = lhs + rhs;
    assign dif  = lhs - rhs;
    assign prod = lhs * rhs;

    always_comb begin
        case (kind)
            TK_SUB:  res = dif;
            TK_MUL:  res = prod;
            default: res = sum;
        endcase
    end

endmodule

// File: rtl/rpn_divider.sv
module rpn_divider #(
    parameter int W = 16,
    localparam int CW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);

    logic [W-1:0]  quo_q, dvs_q;
    logic [W:0]    rem_q, rem_sh, rem_dif;
    logic [CW-1:0] left_q;
    logic          neg_q, done_q, fits;

    function automatic logic [W-1:0] mag(logic [W-1:0] x);
        return x[W-1] ? (~x + 1'b1) : x;
    endfunction

    assign rem_sh  = {rem_q[W-1:0], quo_q[W-1]};
    assign rem_dif = rem_sh - {1'b0, dvs_q};
    assign fits    = (rem_sh >= {1'b0, dvs_q});

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            dvs_q  <= '0;
            rem_q  <= '0;
            left_q <= '0;
            neg_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                quo_q  <= mag(dividend);
                dvs_q  <= mag(divisor);
                rem_q  <= '0;
                neg_q  <= dividend[W-1] ^ divisor[W-1];
                left_q <= CW'(W);
            end else if (left_q != '0) begin
                rem_q  <= fits ? rem_dif : rem_sh;
                quo_q  <= {quo_q[W-2:0], fits};
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) done_q <= 1'b1;
            end
        end
    end

    assign done     = done_q;
    assign quotient = neg_q ? (~quo_q + 1'b1) : quo_q;

endmodule

// File: rtl/rpn_ctrl.sv
module rpn_ctrl
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_kind,
    input  logic [W-1:0]     in_value,
    output logic             in_ready,
    input  logic [W-1:0]     stk_top,
    input  logic [CNT_W-1:0] stk_count,
    input  logic             stk_full,
    input  logic [W-1:0]     alu_res,
    input  logic             div_done,
    input  logic [W-1:0]     div_quo,
    output stk_op_e          sop,
    output logic [W-1:0]     sdata,
    output logic             div_start,
    output logic             res_valid,
    output logic [W-1:0]     res_value,
    output err_flags_t       errs
);

    ctl_state_e state_q, state_d;
    tok_kind_e  kind;
    err_flags_t errs_d, errs_q;
    logic       emit_d, emit_q, two_avail;
    logic [W-1:0] res_q;

    assign kind      = tok_kind_e'(in_kind);
    assign in_ready  = (state_q == CT_IDLE);
    assign two_avail = (int'(stk_count) >= 2);

    always_comb begin
        sop       = SOP_HOLD;
        sdata     = '0;
        div_start = 1'b0;
        state_d   = state_q;
        errs_d    = '0;
        emit_d    = 1'b0;
        if (state_q == CT_DIVIDE) begin
            if (div_done) begin
                sop     = SOP_FOLD;
                sdata   = div_quo;
                state_d = CT_IDLE;
            end
        end else if (in_valid) begin
            if (kind == TK_NUM) begin
                if (stk_full) begin
                    errs_d.ovf = 1'b1;
                end else begin
                    sop   = SOP_PUSH;
                    sdata = in_value;
                end
            end else if (is_arith(kind)) begin
                if (!two_avail) begin
                    errs_d.unf = 1'b1;
                end else if (kind != TK_DIV) begin
                    sop   = SOP_FOLD;
                    sdata = alu_res;
                end else if (stk_top == '0) begin
                    errs_d.dz = 1'b1;
                    sop       = SOP_FOLD;
                    sdata     = '0;
                end else begin
                    div_start = 1'b1;
                    state_d   = CT_DIVIDE;
                end
            end else if (kind == TK_END) begin
                if (int'(stk_count) == 1) begin
                    sop    = SOP_POP;
                    emit_d = 1'b1;
                end else begin
                    sop        = SOP_CLEAR;
                    errs_d.bad = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CT_IDLE;
            errs_q  <= '0;
            emit_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            state_q <= state_d;
            errs_q  <= errs_d;
            emit_q  <= emit_d;
            if (emit_d) res_q <= stk_top;
        end
    end

    assign res_valid = emit_q;
    assign res_value = res_q;
    assign errs      = errs_q;

endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [2:0]   in_kind,
    input  logic [W-1:0] in_value,
    output logic         res_valid,
    output logic [W-1:0] res_value,
    output logic         stk_empty,
    output logic         stk_full,
    output logic         err_overflow,
    output logic         err_underflow,
    output logic         err_divzero,
    output logic         err_malformed
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    stk_op_e          sop;
    logic [W-1:0]     sdata, top, nxt, alu_res, div_quo;
    logic [CNT_W-1:0] count;
    logic             div_start, div_done, full_i;
    err_flags_t       errs;

    rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst(rst), .op(sop), .wdata(sdata),
        .top(top), .nxt(nxt), .count(count),
        .empty(stk_empty), .full(full_i)
    );

    rpn_alu #(.W(W)) u_alu (
        .kind(tok_kind_e'(in_kind)), .lhs(nxt), .rhs(top), .res(alu_res)
    );

    rpn_divider #(.W(W)) u_div (
        .clk(clk), .rst(rst), .start(div_start),
        .dividend(nxt), .divisor(top),
        .done(div_done), .quotient(div_quo)
    );

    rpn_ctrl #(.W(W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_kind(in_kind), .in_value(in_value),
        .in_ready(in_ready),
        .stk_top(top), .stk_count(count), .stk_full(full_i),
        .alu_res(alu_res), .div_done(div_done), .div_quo(div_quo),
        .sop(sop), .sdata(sdata), .div_start(div_start),
        .res_valid(res_valid), .res_value(res_value), .errs(errs)
    );

    assign stk_full      = full_i;
    assign err_overflow  = errs.ovf;
    assign err_underflow = errs.unf;
    assign err_divzero   = errs.dz;
    assign err_malformed = errs.bad;

endmodule

// File: rtl/rpn_eval_chk.sv
module rpn_eval_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic res_valid,
    input logic stk_empty,
    input logic stk_full,
    input logic err_overflow,
    input logic err_underflow,
    input logic err_divzero,
    input logic err_malformed
);

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({err_overflow, err_underflow, err_divzero, err_malformed})); // R11

    AST_EMPTY_FULL_APART: assert property (@(posedge clk) disable iff (rst)
        !(stk_empty && stk_full)); // R2

    AST_IDLE_KEEPS_STACK: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> ($stable(stk_empty) && $stable(stk_full))); // R2

    AST_RESULT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> stk_empty); // R8

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R11

    AST_NO_RESULT_WHILE_DIV: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> !res_valid); // R4

    AST_OVERFLOW_FULL: assert property (@(posedge clk) disable iff (rst)
        err_overflow |-> stk_full); // R7

    AST_DIVZERO_KEEPS_ONE: assert property (@(posedge clk) disable iff (rst)
        err_divzero |-> !stk_empty); // R5

    AST_MALFORMED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        err_malformed |-> stk_empty); // R9

endmodule

bind rpn_eval rpn_eval_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .res_valid(res_valid), .stk_empty(stk_empty), .stk_full(stk_full),
    .err_overflow(err_overflow), .err_underflow(err_underflow),
    .err_divzero(err_divzero), .err_malformed(err_malformed)
);

// File: tb/rpn_eval_test.sv
module rpn_eval_test;

    localparam int CLK_NS = 10;
    localparam int W      = 16;
    localparam int DEPTH  = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_kind = 3'd0;
    logic [W-1:0] in_value = '0;
    logic         res_valid;
    logic [W-1:0] res_value;
    logic         stk_empty, stk_full;
    logic         err_overflow, err_underflow, err_divzero, err_malformed;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    int n_ovf, n_unf, n_dz, n_bad, n_res;
    logic [W-1:0] got_res;

    logic [W-1:0] mstk [DEPTH];
    int mcnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    rpn_eval #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_value(in_value),
        .res_valid(res_valid), .res_value(res_value),
        .stk_empty(stk_empty), .stk_full(stk_full),
        .err_overflow(err_overflow), .err_underflow(err_underflow),
        .err_divzero(err_divzero), .err_malformed(err_malformed)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n_ovf += int'(err_overflow);
            n_unf += int'(err_underflow);
            n_dz  += int'(err_divzero);
            n_bad += int'(err_malformed);
            if (res_valid) begin
                n_res++;
                got_res = res_value;
            end
        end
    end

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    function automatic logic [W-1:0] ref_op(int k, logic [W-1:0] l, logic [W-1:0] r);
        int li, ri;
        li = int'($signed(l));
        ri = int'($signed(r));
        case (k)
            1: return W'(li + ri);
            2: return W'(li - ri);
            3: return W'(li * ri);
            default: return (ri == 0) ? '0 : W'(li / ri);
        endcase
    endfunction

    task automatic send(int k, logic [W-1:0] v);
        int e_ovf = 0, e_unf = 0, e_dz = 0, e_bad = 0, e_res = 0;
        bit e_div = 0;
        logic [W-1:0] e_val = '0;
        string req;
        case (k)
            0: req = (mcnt == DEPTH) ? "R7" : "R2";
            1, 2, 3: req = (mcnt < 2) ? "R6" : "R3";
            4: req = (mcnt < 2) ? "R6" : (mstk[mcnt-1] == '0 ? "R5" : "R4");
            5: req = (mcnt == 1) ? "R8" : "R9";
            default: req = "R10";
        endcase
        if (k == 0) begin
            if (mcnt == DEPTH) e_ovf = 1;
            else begin mstk[mcnt] = v; mcnt++; end
        end else if (k >= 1 && k <= 4) begin
            if (mcnt < 2) e_unf = 1;
            else begin
                if (k == 4 && mstk[mcnt-1] == '0) e_dz = 1;
                if (k == 4 && mstk[mcnt-1] != '0) e_div = 1;
                mstk[mcnt-2] = ref_op(k, mstk[mcnt-2], mstk[mcnt-1]);
                mcnt--;
            end
        end else if (k == 5) begin
            if (mcnt == 1) begin e_res = 1; e_val = mstk[0]; end
            else e_bad = 1;
            mcnt = 0;
        end
        while (!in_ready) @(negedge clk);
        n_ovf = 0; n_unf = 0; n_dz = 0; n_bad = 0; n_res = 0;
        in_kind  = 3'(k);
        in_value = v;
        in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        @(negedge clk);
        if (e_div) check(!in_ready, "R4", "ready during divide", in_ready, 0);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        check(n_ovf == e_ovf, (e_ovf != 0) ? "R7" : "R11", "overflow pulses", n_ovf, e_ovf);
        check(n_unf == e_unf, (e_unf != 0) ? "R6" : "R11", "underflow pulses", n_unf, e_unf);
        check(n_dz == e_dz, (e_dz != 0) ? "R5" : "R11", "divzero pulses", n_dz, e_dz);
        check(n_bad == e_bad, (e_bad != 0) ? "R9" : "R11", "malformed pulses", n_bad, e_bad);
        check(n_res == e_res, req, "result pulses", n_res, e_res);
        if (e_res != 0 && n_res == 1)
            check(got_res == e_val, req, "result value", longint'($signed(got_res)), longint'($signed(e_val)));
        check(stk_empty == (mcnt == 0), req, "empty flag", stk_empty, mcnt == 0);
        check(stk_full == (mcnt == DEPTH), req, "full flag", stk_full, mcnt == DEPTH);
    endtask

    task automatic num(int v);
        send(0, W'(v));
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(stk_empty == 1'b1, "R1", "reset empty", stk_empty, 1);
        check(stk_full == 1'b0, "R1", "reset full", stk_full, 0);
        check(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
        check(res_valid == 1'b0, "R1", "reset result", res_valid, 0);
        check({err_overflow, err_underflow, err_divzero, err_malformed} == 4'b0,
              "R1", "reset errors", {err_overflow, err_underflow, err_divzero, err_malformed}, 0);

        // R3: operand order, 7 - 3 = 4
        num(7); num(3); send(2, 0); send(5, 0);
        // R3: 3 - 7 wraps negative, product wraps modulo 2^W
        num(3); num(7); send(2, 0); send(5, 0);
        num(300); num(300); send(3, 0); send(5, 0);
        num(32767); num(1); send(1, 0); send(5, 0);
        // R4: truncation toward zero and the wrap case
        num(-7); num(2); send(4, 0); send(5, 0);
        num(7); num(-2); send(4, 0); send(5, 0);
        num(-32768); num(-1); send(4, 0); send(5, 0);
        num(100); num(7); send(4, 0); send(5, 0);
        // R5: zero divisor
        num(5); num(0); send(4, 0); send(5, 0);
        // R6: underflow leaves the contents alone
        send(1, 0); num(9); send(1, 0); send(4, 0); send(5, 0);
        // R7: overflow on a full stack drops the token
        for (int i = 0; i < DEPTH; i++) num(i + 1);
        num(99);
        for (int i = 0; i < DEPTH - 1; i++) send(1, 0);
        send(5, 0);
        // R9: malformed ends and recovery
        send(5, 0);
        num(4); num(5); send(5, 0);
        num(11); send(5, 0);
        // R10: reserved kinds have no effect
        num(21); send(6, 16'h1234); send(7, 0); send(5, 0);

        // random mix
        for (int t = 0; t < 600; t++) begin
            int r, k;
            logic [W-1:0] v;
            r = int'($urandom_range(0, 99));
            if (r < 45) k = 0;
            else if (r < 85) k = 1 + int'($urandom_range(0, 3));
            else if (r < 95) k = 5;
            else k = 6 + int'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) v = W'($urandom);
            else v = W'(int'($urandom_range(0, 20)) - 10);
            send(k, v);
        end
        finish_run();
    end

endmodule